// File: doc/BRIEF.md
# Compare/Capture Timer-Counter

A peripheral built around one counter and four compare/capture channels. In timer mode the counter advances on ticks derived from a base-clock enable through a power-of-two prescaler. In counter mode it advances by one on each count strobe. The counter width is selectable, and the counter wraps at the selected width. Each channel holds a compare value. When an increment makes the counter equal to that value, the channel's sticky event flag is set. A capture strobe instead loads the channel with the live counter value.

Per-channel shortcut bits can make a match zero the counter or halt the timer. An interrupt-enable mask gates the event flags onto one interrupt line. Software reaches every setting through a simple word-addressed register port. Register writes take effect at the clock edge. Reads are combinational from the addressed register.

Top module: `tmr_cc_unit`

## Requirements
- R1: The width code (address 8, bits 1:0) selects the counter width: code 0 gives 16 bits, code 1 gives 8 bits, code 2 gives 24 bits and code 3 gives 32 bits. An increment from the all-ones value of that width yields zero.
- R2: The prescaler (address 9) holds a value p. A write above 9 stores 9. In timer mode while running, the counter advances once every 2^p asserted base ticks, counted from the start or clear task.
- R3: A channel i match is an increment whose result equals compare register i. A match sets event flag i (address i, bit 0, for i from 0 to 3). The flag is cleared only by writing zero to address i. A nonzero write leaves it unchanged, and a match in the same cycle as the clearing write wins.
- R4: Shortcut register (address 4): a match on channel i with bit i set makes the counter zero instead of the matched value. A match with bit 8+i set halts the timer. All other bits read as zero.
- R5: irq_o is high exactly when some channel has both its event flag and its enable bit set.
- R6: A write to address 5 ORs data bits 19:16 into the enable mask. A write to address 6 clears the mask bits that are set in data bits 19:16. Reading either address returns the mask in bits 19:16.
- R7: Mode register (address 7, bit 0): 0 selects timer mode and 1 selects counter mode. The start task runs the timer only in timer mode. The count task increments only in counter mode, whether or not the timer is running. Stop or shutdown halts the timer, and a halt wins over a start in the same cycle.
- R8: The clear task zeroes the counter. It wins over an increment in the same cycle and never produces a match.
- R9: A capture strobe on channel i loads compare register i (address 10+i) with the counter value from before that cycle's increment. A capture wins over a software write to the same register.
- R10: A software write to a compare register stores the data masked to the counter width in force at the time of the write.
- R11: Reset zeroes the counter, the running state, the event flags, the compare registers, the shortcuts, the enable mask, the mode, the width code and the prescaler. Unmapped addresses read as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| base_tick_i | input | 1 | Base-clock enable feeding the prescaler |
| start_i | input | 1 | Start task |
| stop_i | input | 1 | Stop task |
| shutdown_i | input | 1 | Shutdown task |
| count_i | input | 1 | Count task |
| clear_i | input | 1 | Clear task |
| capture_i | input | 4 | Capture strobe per channel |
| reg_wr_i | input | 1 | Register write strobe |
| reg_addr_i | input | 4 | Register word address |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Register read data for reg_addr_i |
| evt_o | output | 4 | Sticky compare event flags |
| irq_o | output | 1 | Interrupt request |

## Verification
Directed sequences drive the counter in counter mode through an 8-bit wrap, a clear-on-match shortcut and a clear that coincides with a count. They also place a capture on the same edge as an increment. Together these separate pre-increment capture from post-increment capture, and clear priority from count priority. Timer-mode runs at a prescaler of 2 show whether the tick spacing and the stop shortcut act on the right edge. Writes of a masked compare value, a clamped prescaler and a nonzero event value expose errors in write filtering. Long random mixes of tasks and writes, at small compare values, are compared cycle by cycle with a behavioural model, which finds collisions between matches, clears and writes that the directed cases miss.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  localparam int unsigned NUM_CH  = 4;
  localparam int unsigned CNT_W   = 32;
  localparam int unsigned PSC_W   = 4;
  localparam int unsigned PSC_MAX = 9;
  localparam int unsigned DIV_W   = PSC_MAX;
  localparam int unsigned ADDR_W  = 4;
  localparam int unsigned DATA_W  = 32;

  localparam int unsigned ADDR_EVT0    = 0;
  localparam int unsigned ADDR_SHORTS  = NUM_CH;
  localparam int unsigned ADDR_IEN_SET = NUM_CH + 1;
  localparam int unsigned ADDR_IEN_CLR = NUM_CH + 2;
  localparam int unsigned ADDR_MODE    = NUM_CH + 3;
  localparam int unsigned ADDR_WIDTH   = NUM_CH + 4;
  localparam int unsigned ADDR_PSC     = NUM_CH + 5;
  localparam int unsigned ADDR_CC0     = NUM_CH + 6;

  localparam int unsigned SC_STOP_LSB = 8;
  localparam int unsigned IEN_LSB     = 16;

  typedef enum logic {
    MODE_TIMER   = 1'b0,
    MODE_COUNTER = 1'b1
  } mode_e;

  function automatic logic [CNT_W-1:0] width_mask(input logic [1:0] code);
    int unsigned bits;
    case (code)
      2'd0:    bits = 16;
      2'd1:    bits = 8;
      2'd2:    bits = 24;
      default: bits = 32;
    endcase
    return CNT_W'((64'd1 << bits) - 64'd1);
  endfunction
endpackage

// File: rtl/tmr_prescaler.sv
module tmr_prescaler #(
  parameter int unsigned DIV_W = 9,
  parameter int unsigned PSC_W = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             base_tick_i,
  input  logic             restart_i,
  input  logic [PSC_W-1:0] psc_i,
  output logic             tick_o
);
  logic [DIV_W-1:0] div_q;
  logic [DIV_W-1:0] pmask;

  assign pmask  = DIV_W'((64'd1 << psc_i) - 64'd1);
  assign tick_o = base_tick_i && ((div_q & pmask) == pmask);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)          div_q <= '0;
    else if (restart_i)   div_q <= '0;
    else if (base_tick_i) div_q <= div_q + 1'b1;
  end
endmodule

// File: rtl/tmr_channel.sv
module tmr_channel #(
  parameter int unsigned CNT_W = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             inc_i,
  input  logic [CNT_W-1:0] cnt_i,
  input  logic [CNT_W-1:0] cnt_nxt_i,
  input  logic [CNT_W-1:0] mask_i,
  input  logic             cap_i,
  input  logic             cc_we_i,
  input  logic             evt_clr_i,
  input  logic [CNT_W-1:0] wdata_i,
  output logic [CNT_W-1:0] cc_o,
  output logic             evt_o,
  output logic             hit_o
);
  logic [CNT_W-1:0] cc_q;
  logic             evt_q;

  assign hit_o = inc_i && (cnt_nxt_i == cc_q);
  assign cc_o  = cc_q;
  assign evt_o = evt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cc_q  <= '0;
      evt_q <= 1'b0;
    end else begin
      // capture takes the pre-increment value and beats a software write
      if (cap_i)        cc_q <= cnt_i;
      else if (cc_we_i) cc_q <= wdata_i & mask_i;
      if (hit_o)          evt_q <= 1'b1;
      else if (evt_clr_i) evt_q <= 1'b0;
    end
  end
endmodule

// File: rtl/tmr_cc_unit.sv
module tmr_cc_unit
  import tmr_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              base_tick_i,
  input  logic              start_i,
  input  logic              stop_i,
  input  logic              shutdown_i,
  input  logic              count_i,
  input  logic              clear_i,
  input  logic [NUM_CH-1:0] capture_i,
  input  logic              reg_wr_i,
  input  logic [ADDR_W-1:0] reg_addr_i,
  input  logic [DATA_W-1:0] reg_wdata_i,
  output logic [DATA_W-1:0] reg_rdata_o,
  output logic [NUM_CH-1:0] evt_o,
  output logic              irq_o
);
  logic [CNT_W-1:0]  cnt_q, cnt_nxt, mask;
  logic              run_q;
  mode_e             mode_q;
  logic [1:0]        width_q;
  logic [PSC_W-1:0]  psc_q;
  logic [NUM_CH-1:0] sc_clr_q, sc_stop_q, ien_q, hit;
  logic [CNT_W-1:0]  cc_arr [NUM_CH];
  logic              tick, inc, halt;

  function automatic logic wr_at(input int unsigned a);
    return reg_wr_i && (reg_addr_i == ADDR_W'(a));
  endfunction

  assign mask    = width_mask(width_q);
  assign cnt_nxt = CNT_W'(cnt_q + 1'b1) & mask;
  assign inc     = ((mode_q == MODE_TIMER) && run_q && tick) ||
                   ((mode_q == MODE_COUNTER) && count_i);
  assign halt    = stop_i || shutdown_i || |(hit & sc_stop_q);
  assign irq_o   = |(evt_o & ien_q);

  tmr_prescaler #(.DIV_W(DIV_W), .PSC_W(PSC_W)) u_psc (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .base_tick_i(base_tick_i),
    .restart_i  (start_i || clear_i),
    .psc_i      (psc_q),
    .tick_o     (tick)
  );

  for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
    tmr_channel #(.CNT_W(CNT_W)) u_ch (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .inc_i    (inc),
      .cnt_i    (cnt_q),
      .cnt_nxt_i(cnt_nxt),
      .mask_i   (mask),
      .cap_i    (capture_i[g]),
      .cc_we_i  (wr_at(ADDR_CC0 + g)),
      .evt_clr_i(wr_at(ADDR_EVT0 + g) && (reg_wdata_i == '0)),
      .wdata_i  (CNT_W'(reg_wdata_i)),
      .cc_o     (cc_arr[g]),
      .evt_o    (evt_o[g]),
      .hit_o    (hit[g])
    );
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      run_q <= 1'b0;
    end else begin
      if (clear_i)  cnt_q <= '0;
      else if (inc) cnt_q <= |(hit & sc_clr_q) ? '0 : cnt_nxt;
      if (halt)                                  run_q <= 1'b0;
      else if (start_i && mode_q == MODE_TIMER)  run_q <= 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q    <= MODE_TIMER;
      width_q   <= '0;
      psc_q     <= '0;
      sc_clr_q  <= '0;
      sc_stop_q <= '0;
      ien_q     <= '0;
    end else begin
      if (wr_at(ADDR_MODE))  mode_q  <= mode_e'(reg_wdata_i[0]);
      if (wr_at(ADDR_WIDTH)) width_q <= reg_wdata_i[1:0];
      if (wr_at(ADDR_PSC))
        psc_q <= (reg_wdata_i > DATA_W'(PSC_MAX)) ? PSC_W'(PSC_MAX) : reg_wdata_i[PSC_W-1:0];
      if (wr_at(ADDR_SHORTS)) begin
        sc_clr_q  <= reg_wdata_i[NUM_CH-1:0];
        sc_stop_q <= reg_wdata_i[SC_STOP_LSB +: NUM_CH];
      end
      if (wr_at(ADDR_IEN_SET))      ien_q <= ien_q | reg_wdata_i[IEN_LSB +: NUM_CH];
      else if (wr_at(ADDR_IEN_CLR)) ien_q <= ien_q & ~reg_wdata_i[IEN_LSB +: NUM_CH];
    end
  end

  always_comb begin
    reg_rdata_o = '0;
    case (reg_addr_i)
      ADDR_W'(ADDR_SHORTS): begin
        reg_rdata_o[NUM_CH-1:0]              = sc_clr_q;
        reg_rdata_o[SC_STOP_LSB +: NUM_CH]   = sc_stop_q;
      end
      ADDR_W'(ADDR_IEN_SET), ADDR_W'(ADDR_IEN_CLR):
        reg_rdata_o[IEN_LSB +: NUM_CH] = ien_q;
      ADDR_W'(ADDR_MODE):  reg_rdata_o[0]       = mode_q;
      ADDR_W'(ADDR_WIDTH): reg_rdata_o[1:0]     = width_q;
      ADDR_W'(ADDR_PSC):   reg_rdata_o[PSC_W-1:0] = psc_q;
      default: ;
    endcase
    for (int i = 0; i < NUM_CH; i++) begin
      if (reg_addr_i == ADDR_W'(ADDR_EVT0 + i)) reg_rdata_o = DATA_W'(evt_o[i]);
      if (reg_addr_i == ADDR_W'(ADDR_CC0 + i))  reg_rdata_o = DATA_W'(cc_arr[i]);
    end
  end
endmodule

// File: rtl/tmr_cc_chk.sv
module tmr_cc_chk
  import tmr_pkg::*;
(
  input logic              clk_i,
  input logic              rst_ni,
  input logic              clear_i,
  input logic              start_i,
  input logic              cap0_i,
  input logic              reg_wr_i,
  input logic [ADDR_W-1:0] reg_addr_i,
  input logic              wdata_zero_i,
  input logic [NUM_CH-1:0] ien_clr_bits_i,
  input logic [NUM_CH-1:0] evt_o,
  input logic              irq_o,
  input logic [CNT_W-1:0]  cnt_q,
  input logic [CNT_W-1:0]  mask,
  input logic              inc,
  input logic              run_q,
  input logic              counter_mode,
  input logic [PSC_W-1:0]  psc_q,
  input logic [CNT_W-1:0]  cc0
);
  AST_WRAP_TO_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (inc && !clear_i && cnt_q == mask) |=> cnt_q == '0); // R1

  AST_PSC_CLAMPED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    psc_q <= PSC_W'(PSC_MAX)); // R2

  for (genvar g = 0; g < NUM_CH; g++) begin : g_evt
    AST_EVT_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (evt_o[g] && !(reg_wr_i && reg_addr_i == ADDR_W'(ADDR_EVT0 + g) && wdata_zero_i))
      |=> evt_o[g]); // R3
  end

  AST_IRQ_NEEDS_EVT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> evt_o != '0); // R5

  AST_IEN_CLR_ALL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_wr_i && reg_addr_i == ADDR_W'(ADDR_IEN_CLR) && ien_clr_bits_i == '1) |=> !irq_o); // R6

  AST_START_IGNORED_COUNTER_MODE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && counter_mode && !run_q) |=> !run_q); // R7

  AST_CLEAR_ZEROES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clear_i |=> cnt_q == '0); // R8

  AST_CAPTURE_PRE_INC: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cap0_i |=> cc0 == $past(cnt_q)); // R9
endmodule

bind tmr_cc_unit tmr_cc_chk u_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .clear_i       (clear_i),
  .start_i       (start_i),
  .cap0_i        (capture_i[0]),
  .reg_wr_i      (reg_wr_i),
  .reg_addr_i    (reg_addr_i),
  .wdata_zero_i  (reg_wdata_i == '0),
  .ien_clr_bits_i(reg_wdata_i[19:16]),
  .evt_o         (evt_o),
  .irq_o         (irq_o),
  .cnt_q         (cnt_q),
  .mask          (mask),
  .inc           (inc),
  .run_q         (run_q),
  .counter_mode  (mode_q == MODE_COUNTER),
  .psc_q         (psc_q),
  .cc0           (cc_arr[0])
);

// File: tb/tmr_cc_unit_tb.sv
module tmr_cc_unit_tb_top;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        base_tick_i = 1'b0, start_i = 1'b0, stop_i = 1'b0, shutdown_i = 1'b0;
  logic        count_i = 1'b0, clear_i = 1'b0;
  logic [3:0]  capture_i = '0;
  logic        reg_wr_i = 1'b0;
  logic [3:0]  reg_addr_i = '0;
  logic [31:0] reg_wdata_i = '0;
  logic [31:0] reg_rdata_o;
  logic [3:0]  evt_o;
  logic        irq_o;

  int total = 0, bad = 0;
  bit done = 0;

  // behavioural model state
  logic [31:0] m_cnt, m_sc, m_div;
  logic [31:0] m_cc [4];
  logic [3:0]  m_evt, m_ien, m_psc;
  logic        m_run, m_mode;
  logic [1:0]  m_wc;

  always #5 clk_i = ~clk_i;

  tmr_cc_unit dut_i (.*);

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic logic [31:0] wmask(input logic [1:0] c);
    case (c)
      2'd0: return 32'h0000_FFFF;
      2'd1: return 32'h0000_00FF;
      2'd2: return 32'h00FF_FFFF;
      default: return 32'hFFFF_FFFF;
    endcase
  endfunction

  function automatic logic [31:0] m_read(input logic [3:0] a);
    if (a < 4)        return {31'b0, m_evt[a[1:0]]};
    else if (a == 4)  return m_sc;
    else if (a == 5 || a == 6) return {12'b0, m_ien, 16'b0};
    else if (a == 7)  return {31'b0, m_mode};
    else if (a == 8)  return {30'b0, m_wc};
    else if (a == 9)  return {28'b0, m_psc};
    else if (a <= 13) return m_cc[a - 4'd10];
    return 32'b0;
  endfunction

  function automatic string req_of(input logic [3:0] a);
    if (a < 4)  return "R3";
    if (a == 4) return "R4";
    if (a == 5 || a == 6) return "R6";
    if (a == 7) return "R7";
    if (a == 8) return "R1";
    if (a == 9) return "R2";
    if (a <= 13) return "R9";
    return "R11";
  endfunction

  task automatic m_reset();
    m_cnt = 0; m_sc = 0; m_div = 0; m_evt = 0; m_ien = 0; m_psc = 0;
    m_run = 0; m_mode = 0; m_wc = 0;
    for (int i = 0; i < 4; i++) m_cc[i] = 0;
  endtask

  task automatic m_step();
    logic [31:0] mk, pm, nx, n_cnt;
    logic [3:0]  hit, n_evt;
    logic        tk, inc, csc, ssc, n_run;
    logic [31:0] n_cc [4];
    mk = wmask(m_wc);
    pm = (32'd1 << m_psc) - 1;
    tk = base_tick_i && ((m_div & pm) == pm);
    inc = (!m_mode && m_run && tk) || (m_mode && count_i);
    nx = (m_cnt + 1) & mk;
    for (int i = 0; i < 4; i++) hit[i] = inc && (nx == m_cc[i]);
    csc = |(hit & m_sc[3:0]);
    ssc = |(hit & m_sc[11:8]);
    n_cnt = clear_i ? 0 : inc ? (csc ? 0 : nx) : m_cnt;
    n_run = (stop_i || shutdown_i || ssc) ? 1'b0 : (start_i && !m_mode) ? 1'b1 : m_run;
    for (int i = 0; i < 4; i++) begin
      n_evt[i] = hit[i] ? 1'b1 :
                 (reg_wr_i && reg_addr_i == 4'(i) && reg_wdata_i == 0) ? 1'b0 : m_evt[i];
      n_cc[i] = capture_i[i] ? m_cnt :
                (reg_wr_i && reg_addr_i == 4'(10 + i)) ? (reg_wdata_i & mk) : m_cc[i];
    end
    m_div = (start_i || clear_i) ? 0 : base_tick_i ? ((m_div + 1) & 32'h1FF) : m_div;
    if (reg_wr_i) begin
      case (reg_addr_i)
        4'd4: m_sc = reg_wdata_i & 32'h0F0F;
        4'd5: m_ien = m_ien | reg_wdata_i[19:16];
        4'd6: m_ien = m_ien & ~reg_wdata_i[19:16];
        4'd7: m_mode = reg_wdata_i[0];
        4'd8: m_wc = reg_wdata_i[1:0];
        4'd9: m_psc = (reg_wdata_i > 9) ? 4'd9 : reg_wdata_i[3:0];
        default: ;
      endcase
    end
    m_cnt = n_cnt; m_run = n_run; m_evt = n_evt;
    for (int i = 0; i < 4; i++) m_cc[i] = n_cc[i];
  endtask

  // inputs are set just after a negedge; this runs one clock cycle
  task automatic cyc();
    #1;
    if (!reg_wr_i) chk(req_of(reg_addr_i), reg_rdata_o, m_read(reg_addr_i));
    m_step();
    @(negedge clk_i);
    chk("R3", {28'b0, evt_o}, {28'b0, m_evt});
    chk("R5", {31'b0, irq_o}, {31'b0, |(m_evt & m_ien)});
    start_i = 0; stop_i = 0; shutdown_i = 0; count_i = 0; clear_i = 0;
    capture_i = 0; reg_wr_i = 0;
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    reg_wr_i = 1; reg_addr_i = a; reg_wdata_i = d;
    cyc();
  endtask

  task automatic rd_chk(input string req, input logic [3:0] a, input logic [31:0] exp);
    reg_addr_i = a;
    #1 chk(req, reg_rdata_o, exp);
    cyc();
  endtask

  task automatic counts(input int n);
    for (int i = 0; i < n; i++) begin count_i = 1; cyc(); end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  initial begin
    #1_500_000;
    bad++;
    $display("FAIL watchdog: actual=hung expected=finished");
    finish_run();
  end

  initial begin
    void'($urandom(32'h5EED_0042));
    m_reset();
    repeat (3) @(negedge clk_i);
    // R11: reset state at the ports
    for (int a = 0; a < 16; a++) begin
      reg_addr_i = 4'(a);
      #1 chk("R11", reg_rdata_o, 32'h0);
    end
    chk("R11", {27'b0, evt_o, irq_o}, 32'h0);
    @(negedge clk_i);
    rst_ni = 1;

    // R10, R1: 8-bit width, counter mode
    wr(4'd8, 32'd1);
    wr(4'd7, 32'd1);
    wr(4'd10, 32'h1FF);
    rd_chk("R10", 4'd10, 32'hFF);
    counts(255);
    capture_i = 4'b0010; cyc();
    rd_chk("R1", 4'd11, 32'hFF);
    chk("R3", {31'b0, evt_o[0]}, 32'd1);
    counts(1);
    capture_i = 4'b0010; cyc();
    rd_chk("R1", 4'd11, 32'h0);
    // R3: nonzero write keeps flag, zero write clears
    wr(4'd0, 32'h5);
    chk("R3", {31'b0, evt_o[0]}, 32'd1);
    wr(4'd0, 32'h0);
    chk("R3", {31'b0, evt_o[0]}, 32'd0);

    // R8: clear beats count; R9: capture takes pre-increment value
    counts(5);
    count_i = 1; clear_i = 1; cyc();
    capture_i = 4'b0100; cyc();
    rd_chk("R8", 4'd12, 32'h0);
    counts(6);
    count_i = 1; capture_i = 4'b0100; reg_wr_i = 1; reg_addr_i = 4'd12; reg_wdata_i = 32'h77; cyc();
    rd_chk("R9", 4'd12, 32'd6);

    // R4: clear shortcut on channel 2
    clear_i = 1; cyc();
    wr(4'd12, 32'd3);
    wr(4'd4, 32'hFFFF_F004);
    rd_chk("R4", 4'd4, 32'h0000_0004);
    counts(3);
    capture_i = 4'b1000; cyc();
    rd_chk("R4", 4'd13, 32'h0);
    chk("R3", {31'b0, evt_o[2]}, 32'd1);

    // R5, R6: enable gating
    wr(4'd5, 32'h0004_0000);
    chk("R5", {31'b0, irq_o}, 32'd1);
    rd_chk("R6", 4'd6, 32'h0004_0000);
    wr(4'd6, 32'h0004_0000);
    chk("R5", {31'b0, irq_o}, 32'd0);
    wr(4'd5, 32'h000F_0000);
    rd_chk("R6", 4'd5, 32'h000F_0000);
    wr(4'd6, 32'h0003_0000);
    rd_chk("R6", 4'd5, 32'h000C_0000);

    // R7: start ignored in counter mode
    wr(4'd4, 32'h0);
    clear_i = 1; cyc();
    start_i = 1; cyc();
    wr(4'd7, 32'd0);
    for (int i = 0; i < 10; i++) begin base_tick_i = 1; cyc(); end
    capture_i = 4'b0001; cyc();
    rd_chk("R7", 4'd10, 32'h0);
    // R7: count ignored in timer mode
    counts(4);
    capture_i = 4'b0001; cyc();
    rd_chk("R7", 4'd10, 32'h0);

    // R2: prescaler clamp, then tick spacing at p=2
    wr(4'd9, 32'd15);
    rd_chk("R2", 4'd9, 32'd9);
    wr(4'd9, 32'd2);
    start_i = 1; cyc();
    for (int i = 0; i < 8; i++) cyc();
    capture_i = 4'b0001; cyc();
    rd_chk("R2", 4'd10, 32'd2);
    // R7: stop wins over start
    stop_i = 1; start_i = 1; cyc();
    for (int i = 0; i < 12; i++) cyc();
    capture_i = 4'b0001; cyc();
    rd_chk("R7", 4'd10, 32'd2);

    // R4: stop shortcut on channel 1 at value 2
    wr(4'd9, 32'd0);
    wr(4'd11, 32'd2);
    wr(4'd4, 32'h0000_0200);
    clear_i = 1; cyc();
    start_i = 1; cyc();
    for (int i = 0; i < 12; i++) cyc();
    capture_i = 4'b0001; cyc();
    rd_chk("R4", 4'd10, 32'd2);

    // random mix compared against the model
    for (int n = 0; n < 4000; n++) begin
      int r;
      base_tick_i = ($urandom % 4) != 0;
      r = $urandom % 100;
      start_i    = r < 5;
      stop_i     = r == 5 || r == 6;
      shutdown_i = r == 7;
      clear_i    = ($urandom % 40) == 0;
      count_i    = ($urandom % 3) == 0;
      for (int c = 0; c < 4; c++) capture_i[c] = ($urandom % 30) == 0;
      reg_addr_i = 4'($urandom % 16);
      if (($urandom % 5) == 0) begin
        reg_wr_i = 1;
        case (reg_addr_i)
          4'd0, 4'd1, 4'd2, 4'd3: reg_wdata_i = ($urandom % 3 == 0) ? $urandom : 32'h0;
          4'd9: reg_wdata_i = $urandom % 12;
          4'd8: reg_wdata_i = ($urandom % 2) ? 32'd1 : $urandom;
          4'd10, 4'd11, 4'd12, 4'd13: reg_wdata_i = $urandom % 24;
          default: reg_wdata_i = $urandom;
        endcase
      end
      cyc();
    end
    finish_run();
  end
endmodule